// File: doc/BRIEF.md
# Implicit-Length Packed String Compare Unit

This unit compares two 128-bit operands. Each operand holds a short string that ends at its first zero element. An element is either one of sixteen bytes or one of eight 16-bit words. The unit finds the terminator in each operand and marks every element below it as valid. It then compares elements pairwise in one of four aggregation modes: match-any-of-set, inside-a-range, position-by-position equality, and substring search. The resulting bit vector can be inverted in full, or inverted only over the valid part of the second operand. The unit returns the position of the lowest or the highest set bit, together with six status flags.

The unit sits in an execution datapath. A caller presents both operands and the 8-bit control byte, and raises `start_i` for one cycle. One cycle later `done_o` pulses and the registered result appears. The result holds until the next start.

Control byte layout:
- bit 0: element size, where 0 means bytes and 1 means words.
- bit 1: signed compare, which is used only by the range mode.
- bits 3:2: aggregation mode.
- bits 5:4: polarity.
- bit 6: index pick, where 0 means lowest and 1 means highest.
- bit 7: no effect.

Top module: `pstr_cmp_unit`

## Requirements
- R1: When `start_i` is high at a rising edge, `done_o` is high for exactly the following cycle. The index and flag outputs change only at such an edge and hold otherwise.
- R2: While `rst` is high at a rising edge, `done_o`, `index_o` and all flags become 0.
- R3: Element size is chosen by control bit 0. With 0, element k is byte k (bits 8k+7:8k), giving 16 elements. With 1, element k is word k (bits 16k+15:16k), giving 8 elements. An element is valid only if its index is below the lowest zero element of its operand, and a zero is judged at the chosen element size.
- R4: Mode 00 (bits 3:2) sets result bit j when valid element j of operand B equals any valid element of operand A.
- R5: Mode 01 reads A as pairs (A[2p] as lower bound, A[2p+1] as upper bound). It sets bit j when valid B[j] lies inclusively inside any pair whose two elements are both valid. Control bit 1 makes the bound compares signed.
- R6: Mode 10 sets bit i when A[i] and B[i] are both valid and equal, or both invalid. The bit is 0 when exactly one of them is valid.
- R7: Mode 11 sets bit j when, for every valid A[i] with j+i below the element count, B[j+i] is valid and equal to A[i]. Positions beyond the element count do not block a match.
- R8: Polarity bits 5:4 select how the result is treated: 00 and 10 pass it through, 01 inverts every in-range bit, and 11 inverts only the bits where B is valid. Polarity is applied before the index is chosen.
- R9: `index_o` is the position of the lowest set result bit when bit 6 is 0, and of the highest when bit 6 is 1. When no bit is set it equals the element count (16 or 8).
- R10: `flag_c_o` is 1 exactly when the final result is nonzero. `flag_o_o` equals result bit 0.
- R11: `flag_z_o` is 1 when operand B holds a zero element within the element count. `flag_s_o` is the same for operand A.
- R12: `flag_a_o` and `flag_p_o` are always 0.
- R13: Control bit 7 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Sample operands and control, one-cycle strobe |
| opa_i | input | 128 | Operand A (pattern or set) |
| opb_i | input | 128 | Operand B (searched string) |
| ctrl_i | input | 8 | Control byte |
| done_o | output | 1 | Result-valid pulse, one cycle after start |
| index_o | output | 5 | Selected bit position, or element count when empty |
| flag_c_o | output | 1 | Result nonzero |
| flag_z_o | output | 1 | Operand B contains a zero element |
| flag_s_o | output | 1 | Operand A contains a zero element |
| flag_o_o | output | 1 | Result bit 0 |
| flag_a_o | output | 1 | Always 0 |
| flag_p_o | output | 1 | Always 0 |

## Verification
The bench builds the unit with its default parameters: sixteen 8-bit lanes, which gives 128-bit operands and both the 16-byte and the 8-word element forms. These parameters bring several cases within reach:
- strings that fill every lane with no terminator, where a substring search runs off the top;
- bytes such as 0x80 and 0xF0, which are far apart under signed and unsigned order;
- words whose low byte is zero but which are not terminators.

A behavioural model in the bench predicts every output for directed cases and for several hundred random control bytes and strings with scattered zeros.

// File: rtl/pstr_pkg.sv
package pstr_pkg;
  // Control byte field positions
  localparam int CTL_WORD   = 0;
  localparam int CTL_SIGNED = 1;
  localparam int CTL_AGG_LO = 2;
  localparam int CTL_POL_LO = 4;
  localparam int CTL_HIGH   = 6;

  typedef enum logic [1:0] {
    AGG_ANY   = 2'b00,
    AGG_RANGE = 2'b01,
    AGG_EACH  = 2'b10,
    AGG_ORDER = 2'b11
  } agg_e;

  typedef enum logic [1:0] {
    POL_PASS  = 2'b00,
    POL_INV   = 2'b01,
    POL_PASS2 = 2'b10,
    POL_VINV  = 2'b11
  } pol_e;
endpackage

// File: rtl/pstr_unpack.sv
// Splits an operand into sign/zero-extended elements of either size.
module pstr_unpack #(
  parameter  int ELEMS  = 16,
  parameter  int BYTE_W = 8,
  localparam int DATA_W = ELEMS * BYTE_W,
  localparam int XW     = 2 * BYTE_W + 1,
  localparam int WORDS  = ELEMS / 2
) (
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       word_i,
  input  logic                       sgn_i,
  output logic [ELEMS-1:0][XW-1:0]   el_o,
  output logic [ELEMS-1:0]           null_o,
  output logic [ELEMS-1:0]           lane_o
);
  for (genvar g = 0; g < ELEMS; g++) begin : g_lane
    logic [BYTE_W-1:0]   bv;
    logic [2*BYTE_W-1:0] wv;
    assign bv = data_i[g*BYTE_W +: BYTE_W];
    if (g < WORDS) begin : g_word
      assign wv = data_i[g*2*BYTE_W +: 2*BYTE_W];
    end else begin : g_noword
      assign wv = '0;
    end
    assign el_o[g]   = word_i ? {sgn_i & wv[2*BYTE_W-1], wv}
                              : {{(BYTE_W+1){sgn_i & bv[BYTE_W-1]}}, bv};
    assign null_o[g] = (el_o[g] == '0);
    assign lane_o[g] = ~word_i | (g < WORDS);
  end
endmodule

// File: rtl/pstr_valid_mask.sv
// Marks elements below the lowest in-range zero element as valid.
module pstr_valid_mask #(
  parameter int ELEMS = 16
) (
  input  logic [ELEMS-1:0] null_i,
  input  logic [ELEMS-1:0] lane_i,
  output logic [ELEMS-1:0] vld_o,
  output logic             any_null_o
);
  logic seen;
  always_comb begin
    seen = 1'b0;
    for (int i = 0; i < ELEMS; i++) begin
      seen     = seen | (null_i[i] & lane_i[i]);
      vld_o[i] = lane_i[i] & ~seen;
    end
    any_null_o = seen;
  end
endmodule

// File: rtl/pstr_agg.sv
// Pairwise compare matrix and the four aggregation modes.
module pstr_agg
  import pstr_pkg::*;
#(
  parameter  int ELEMS  = 16,
  parameter  int BYTE_W = 8,
  localparam int XW     = 2 * BYTE_W + 1,
  localparam int PAIRS  = ELEMS / 2
) (
  input  logic [ELEMS-1:0][XW-1:0] a_el_i,
  input  logic [ELEMS-1:0][XW-1:0] b_el_i,
  input  logic [ELEMS-1:0]         a_vld_i,
  input  logic [ELEMS-1:0]         b_vld_i,
  input  logic [ELEMS-1:0]         lane_i,
  input  agg_e                     mode_i,
  output logic [ELEMS-1:0]         res_o
);
  logic [ELEMS-1:0][ELEMS-1:0] eq_m, ge_m, le_m, ord_t;
  logic [ELEMS-1:0][PAIRS-1:0] rng_t;
  logic [ELEMS-1:0]            any_r, rng_r, each_r, ord_r;

  for (genvar j = 0; j < ELEMS; j++) begin : g_row
    for (genvar i = 0; i < ELEMS; i++) begin : g_col
      assign eq_m[j][i] = (a_el_i[i] == b_el_i[j]);
      assign ge_m[j][i] = ($signed(b_el_i[j]) >= $signed(a_el_i[i]));
      assign le_m[j][i] = ($signed(b_el_i[j]) <= $signed(a_el_i[i]));
      if (j + i < ELEMS) begin : g_in
        assign ord_t[j][i] = ~lane_i[j+i] | ~a_vld_i[i]
                           | (b_vld_i[j+i] & eq_m[j+i][i]);
      end else begin : g_out
        assign ord_t[j][i] = 1'b1;
      end
    end
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign rng_t[j][p] = a_vld_i[2*p] & a_vld_i[2*p+1] & b_vld_i[j]
                         & ge_m[j][2*p] & le_m[j][2*p+1];
    end
    assign any_r[j]  = b_vld_i[j] & |(a_vld_i & eq_m[j]);
    assign rng_r[j]  = |rng_t[j];
    assign each_r[j] = (a_vld_i[j] & b_vld_i[j]) ? eq_m[j][j]
                                                 : (~a_vld_i[j] & ~b_vld_i[j]);
    assign ord_r[j]  = &ord_t[j];
  end

  always_comb begin
    unique case (mode_i)
      AGG_ANY:   res_o = any_r;
      AGG_RANGE: res_o = rng_r;
      AGG_EACH:  res_o = each_r;
      default:   res_o = ord_r;
    endcase
    res_o = res_o & lane_i;
  end
endmodule

// File: rtl/pstr_idx_sel.sv
// Picks the lowest or highest set position; element count when empty.
module pstr_idx_sel #(
  parameter  int ELEMS = 16,
  localparam int IDX_W = $clog2(ELEMS + 1),
  localparam int WORDS = ELEMS / 2
) (
  input  logic [ELEMS-1:0] vec_i,
  input  logic             word_i,
  input  logic             high_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = word_i ? IDX_W'(WORDS) : IDX_W'(ELEMS);
    if (high_i) begin
      for (int i = 0; i < ELEMS; i++)
        if (vec_i[i]) idx_o = IDX_W'(i);
    end else begin
      for (int i = ELEMS - 1; i >= 0; i--)
        if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pstr_cmp_unit.sv
module pstr_cmp_unit
  import pstr_pkg::*;
#(
  parameter  int ELEMS  = 16,
  parameter  int BYTE_W = 8,
  localparam int DATA_W = ELEMS * BYTE_W,
  localparam int IDX_W  = $clog2(ELEMS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [7:0]        ctrl_i,
  output logic              done_o,
  output logic [IDX_W-1:0]  index_o,
  output logic              flag_c_o,
  output logic              flag_z_o,
  output logic              flag_s_o,
  output logic              flag_o_o,
  output logic              flag_a_o,
  output logic              flag_p_o
);
  localparam int XW = 2 * BYTE_W + 1;

  logic word_m, sgn_m, high_m;
  agg_e agg_m;
  pol_e pol_m;
  assign word_m = ctrl_i[CTL_WORD];
  assign sgn_m  = ctrl_i[CTL_SIGNED];
  assign high_m = ctrl_i[CTL_HIGH];
  assign agg_m  = agg_e'(ctrl_i[CTL_AGG_LO +: 2]);
  assign pol_m  = pol_e'(ctrl_i[CTL_POL_LO +: 2]);

  logic [ELEMS-1:0][XW-1:0] a_el, b_el;
  logic [ELEMS-1:0]         a_nul, b_nul, lane, lane_b_unused;
  logic [ELEMS-1:0]         a_vld, b_vld, raw_res, fin_res;
  logic                     a_any0, b_any0;
  logic [IDX_W-1:0]         idx_c;

  pstr_unpack #(.ELEMS(ELEMS), .BYTE_W(BYTE_W)) u_unp_a (
    .data_i(opa_i), .word_i(word_m), .sgn_i(sgn_m),
    .el_o(a_el), .null_o(a_nul), .lane_o(lane));
  pstr_unpack #(.ELEMS(ELEMS), .BYTE_W(BYTE_W)) u_unp_b (
    .data_i(opb_i), .word_i(word_m), .sgn_i(sgn_m),
    .el_o(b_el), .null_o(b_nul), .lane_o(lane_b_unused));

  pstr_valid_mask #(.ELEMS(ELEMS)) u_vm_a (
    .null_i(a_nul), .lane_i(lane), .vld_o(a_vld), .any_null_o(a_any0));
  pstr_valid_mask #(.ELEMS(ELEMS)) u_vm_b (
    .null_i(b_nul), .lane_i(lane), .vld_o(b_vld), .any_null_o(b_any0));

  pstr_agg #(.ELEMS(ELEMS), .BYTE_W(BYTE_W)) u_agg (
    .a_el_i(a_el), .b_el_i(b_el), .a_vld_i(a_vld), .b_vld_i(b_vld),
    .lane_i(lane), .mode_i(agg_m), .res_o(raw_res));

  always_comb begin
    unique case (pol_m)
      POL_INV:  fin_res = ~raw_res & lane;
      POL_VINV: fin_res = raw_res ^ b_vld;
      default:  fin_res = raw_res;
    endcase
  end

  pstr_idx_sel #(.ELEMS(ELEMS)) u_sel (
    .vec_i(fin_res), .word_i(word_m), .high_i(high_m), .idx_o(idx_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      index_o  <= '0;
      flag_c_o <= 1'b0;
      flag_z_o <= 1'b0;
      flag_s_o <= 1'b0;
      flag_o_o <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        index_o  <= idx_c;
        flag_c_o <= |fin_res;
        flag_z_o <= b_any0;
        flag_s_o <= a_any0;
        flag_o_o <= fin_res[0];
      end
    end
  end

  assign flag_a_o = 1'b0;
  assign flag_p_o = 1'b0;
endmodule

// File: rtl/pstr_cmp_chk.sv
module pstr_cmp_chk #(
  parameter  int ELEMS  = 16,
  parameter  int BYTE_W = 8,
  localparam int DATA_W = ELEMS * BYTE_W,
  localparam int IDX_W  = $clog2(ELEMS + 1),
  localparam int WORDS  = ELEMS / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [7:0]        ctrl_i,
  input logic              done_o,
  input logic [IDX_W-1:0]  index_o,
  input logic              flag_c_o,
  input logic              flag_z_o,
  input logic              flag_o_o
);
  assert_done_follows_R1: assert property (@(posedge clk) disable iff (rst)
    start_i |=> done_o);
  assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !done_o);
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> ($stable(index_o) && $stable(flag_c_o) && $stable(flag_z_o)));
  assert_index_range_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (index_o <= ($past(ctrl_i[0]) ? IDX_W'(WORDS) : IDX_W'(ELEMS))));
  assert_carry_index_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (flag_c_o == (index_o != ($past(ctrl_i[0]) ? IDX_W'(WORDS) : IDX_W'(ELEMS)))));
  assert_ovf_low_R10: assert property (@(posedge clk) disable iff (rst)
    (done_o && flag_o_o && !$past(ctrl_i[6])) |-> (index_o == '0));
  assert_zero_b_R11: assert property (@(posedge clk) disable iff (rst)
    (done_o && ($past(opb_i) == '0)) |-> flag_z_o);
endmodule

bind pstr_cmp_unit pstr_cmp_chk #(.ELEMS(ELEMS), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .opb_i(opb_i), .ctrl_i(ctrl_i),
  .done_o(done_o), .index_o(index_o), .flag_c_o(flag_c_o),
  .flag_z_o(flag_z_o), .flag_o_o(flag_o_o));

// File: tb/pstr_cmp_unit_tb.sv
module pstr_cmp_unit_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] opa = '0, opb = '0;
  logic [7:0]   ctrl = '0;
  logic         done, fc, fz, fs, fo, fa, fp;
  logic [4:0]   idx;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pstr_cmp_unit u_dut (
    .clk(clk), .rst(rst), .start_i(start), .opa_i(opa), .opb_i(opb),
    .ctrl_i(ctrl), .done_o(done), .index_o(idx), .flag_c_o(fc),
    .flag_z_o(fz), .flag_s_o(fs), .flag_o_o(fo), .flag_a_o(fa), .flag_p_o(fp));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input string s);
    logic [127:0] v = '0;
    for (int i = 0; i < s.len() && i < 16; i++) v[i*8 +: 8] = s[i];
    return v;
  endfunction

  function automatic int elv(input logic [127:0] v, input int i, input logic [7:0] c);
    int raw;
    if (c[0]) raw = int'(v[i*16 +: 16]);
    else      raw = int'(v[i*8 +: 8]);
    if (c[1]) begin
      if (c[0] && raw >= 32768) raw -= 65536;
      if (!c[0] && raw >= 128)  raw -= 256;
    end
    return raw;
  endfunction

  function automatic void model(input logic [127:0] a, b, input logic [7:0] c,
                                output int ix, output bit cf, zf, sf, of);
    int n, la, lb;
    int ea[16], eb[16];
    bit r[16];
    n = c[0] ? 8 : 16;
    la = n; lb = n;
    for (int i = 0; i < n; i++) begin
      ea[i] = elv(a, i, c); eb[i] = elv(b, i, c);
    end
    for (int i = n - 1; i >= 0; i--) begin
      if (ea[i] == 0) la = i;
      if (eb[i] == 0) lb = i;
    end
    sf = (la < n); zf = (lb < n);
    for (int j = 0; j < 16; j++) r[j] = 0;
    for (int j = 0; j < n; j++) begin
      case (c[3:2])
        2'b00: for (int i = 0; i < n; i++)
                 if (i < la && j < lb && ea[i] == eb[j]) r[j] = 1;
        2'b01: for (int i = 0; i + 1 < n; i += 2)
                 if (i + 1 < la && j < lb && eb[j] >= ea[i] && eb[j] <= ea[i+1]) r[j] = 1;
        2'b10: r[j] = (j < la && j < lb) ? (ea[j] == eb[j]) : (j >= la && j >= lb);
        default: begin
          r[j] = 1;
          for (int i = 0; j + i < n; i++)
            if (i < la && !(j + i < lb && ea[i] == eb[j+i])) r[j] = 0;
        end
      endcase
      if (c[5:4] == 2'b01) r[j] = !r[j];
      if (c[5:4] == 2'b11 && j < lb) r[j] = !r[j];
    end
    ix = n; cf = 0;
    for (int j = 0; j < n; j++) begin
      if (r[j]) begin
        cf = 1;
        if (c[6] || ix == n) ix = j;
      end
    end
    of = r[0];
  endfunction

  // Drives one operation and compares every output with the model.
  task automatic run(input logic [127:0] a, b, input logic [7:0] c, input string req);
    int ei; bit ecf, ezf, esf, eof;
    model(a, b, c, ei, ecf, ezf, esf, eof);
    @(negedge clk);
    opa = a; opb = b; ctrl = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R1", "done", int'(done), 1);
    chk(int'(idx) == ei, req, "index(R9)", int'(idx), ei);
    chk(fc == ecf, req, "carry(R10)", int'(fc), int'(ecf));
    chk(fo == eof, req, "overflow(R10)", int'(fo), int'(eof));
    chk(fz == ezf, "R11", "zero", int'(fz), int'(ezf));
    chk(fs == esf, "R11", "sign", int'(fs), int'(esf));
    chk(fa == 1'b0 && fp == 1'b0, "R12", "aux/parity", int'({fa, fp}), 0);
  endtask

  task automatic t_reset();
    chk(done == 0 && idx == 0 && {fc, fz, fs, fo} == 0, "R2", "reset state",
        int'({done, idx, fc, fz, fs, fo}), 0);
  endtask

  task automatic t_done_pulse();
    logic [4:0] held;
    run(mk("ab"), mk("xxbx"), 8'h00, "R4");
    held = idx;
    @(negedge clk);
    chk(done == 0, "R1", "done drops", int'(done), 0);
    opa = mk("q"); opb = mk("q");
    repeat (2) @(negedge clk);
    chk(idx == held, "R1", "hold without start", int'(idx), int'(held));
  endtask

  task automatic t_any();
    run(mk("ab"), mk("xxbx"), 8'h00, "R4");
    chk(idx == 2, "R4", "any lowest", int'(idx), 2);
    run(mk("ab"), mk("bxab"), 8'h40, "R4");
    chk(idx == 3, "R4", "any highest", int'(idx), 3);
  endtask

  task automatic t_ranges();
    run(mk("az"), mk("1bc4"), 8'h04, "R5");
    chk(idx == 1, "R5", "range lowest", int'(idx), 1);
    run(mk("az"), mk("1bc4"), 8'h44, "R5");
    chk(idx == 2, "R5", "range highest", int'(idx), 2);
    run(128'h10F0, 128'h8005, 8'h04, "R5");
    chk(idx == 16 && fc == 0, "R5", "unsigned range empty", int'(idx), 16);
    run(128'h10F0, 128'h8005, 8'h06, "R5");
    chk(idx == 0 && fo == 1, "R5", "signed range hit", int'(idx), 0);
  endtask

  task automatic t_each();
    run(mk("abcd"), mk("abxd"), 8'h18, "R6");
    chk(idx == 2, "R6", "each mismatch only", int'(idx), 2);
    run(mk("abcd"), mk("ab"), 8'h18, "R6");
    chk(idx == 2, "R6", "each one-side invalid", int'(idx), 2);
  endtask

  task automatic t_ordered();
    run(mk("cd"), mk("abcdcd"), 8'h0C, "R7");
    chk(idx == 2, "R7", "substring lowest", int'(idx), 2);
    run(mk("cd"), mk("abcdcd"), 8'h4C, "R7");
    chk(idx == 4, "R7", "substring highest", int'(idx), 4);
    run(mk("ab"), mk("xxxxxxxxxxxxxxxa"), 8'h0C, "R7");
    chk(idx == 15 && fz == 0, "R7", "partial match at top", int'(idx), 15);
  endtask

  task automatic t_polarity();
    run(mk("a"), mk("abab"), 8'h30, "R8");
    chk(idx == 1, "R8", "valid-only invert lowest", int'(idx), 1);
    run(mk("a"), mk("abab"), 8'h70, "R8");
    chk(idx == 3, "R8", "valid-only invert highest", int'(idx), 3);
    run(mk("a"), mk("abab"), 8'h20, "R8");
    chk(idx == 0, "R8", "code 10 passes", int'(idx), 0);
    run(mk("a"), mk("abab"), 8'h50, "R8");
    chk(idx == 15, "R8", "full invert highest", int'(idx), 15);
  endtask

  task automatic t_words();
    run(128'h1234, 128'h0000_5678_1234_0001, 8'h01, "R3");
    chk(idx == 1, "R3", "word match", int'(idx), 1);
    run(128'h9999, 128'h1111, 8'h01, "R9");
    chk(idx == 8 && fc == 0, "R9", "word empty gives 8", int'(idx), 8);
    run(128'h0100, 128'h0100, 8'h01, "R3");
    chk(idx == 0, "R3", "word with zero byte is valid", int'(idx), 0);
    run(128'h0100, 128'h0100, 8'h00, "R3");
    chk(idx == 16, "R3", "byte zero terminates", int'(idx), 16);
  endtask

  task automatic t_bit7();
    run(mk("ab"), mk("xxbx"), 8'h80, "R13");
    chk(idx == 2, "R13", "bit7 ignored", int'(idx), 2);
    run(mk("ab"), mk("bxab"), 8'hC0, "R13");
    chk(idx == 3, "R13", "bit7 ignored high", int'(idx), 3);
  endtask

  task automatic t_random();
    logic [7:0] alpha [4] = '{8'h41, 8'h42, 8'h43, 8'hC3};
    for (int n = 0; n < 400; n++) begin
      logic [127:0] a, b;
      for (int k = 0; k < 16; k++) begin
        int ra, rb;
        ra = $urandom_range(0, 11); rb = $urandom_range(0, 11);
        a[k*8 +: 8] = (ra == 0) ? 8'h00 : alpha[ra % 4];
        b[k*8 +: 8] = (rb == 0) ? 8'h00 : alpha[rb % 4];
      end
      run(a, b, 8'($urandom), "R4/R5/R6/R7/R8");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_done_pulse();
    t_any();
    t_ranges();
    t_each();
    t_ordered();
    t_polarity();
    t_words();
    t_bit7();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule